// File: doc/BRIEF.md
# Core Clock Stop and Wake Controller

This block decides when the processor core's clock runs. It holds one 8-bit control register on a simple write and read port. When software has armed it, a stop request from the core switches the core clock enable off. It switches the enable back on when an interrupt arrives whose priority is above a programmable floor. Peripheral clocks are never touched, so peripherals keep running while the core is stopped and can raise the interrupt that restarts it.

Wake-up takes effect on the next clock edge, with no lock wait, because the clock source keeps running. A one-cycle wake indication goes out with the returning enable so that interrupt processing can start. The register also holds a bit that turns off the external bus-clock output driver. Once that bit is set, only reset can turn the driver back on.

Top module: `core_stop_wake`

## Requirements
- R1: After reset the control register reads 0x00, `core_clk_en` is 1, `bus_clk_oe` is 1 and `wake_pulse` is 0.
- R2: The control register sits at address 0x08. Its fields are: bit 7 arms stop, bits 6:4 hold the wake threshold, and bit 3 disables the bus clock. A write to any other address changes nothing, and a read of any other address returns 0x00.
- R3: A `stop_req` sampled high while the stop-arm bit is 1 drives `core_clk_en` to 0 after that same edge. If the bit is 0, the request is ignored and `core_clk_en` stays 1. A request made while the core is already stopped has no effect.
- R4: While stopped, with a threshold n from 0 to 6, an `irq_level` greater than n sampled at an edge drives `core_clk_en` back to 1 after that edge. A lower level keeps the core stopped.
- R5: A threshold of 7 lets no interrupt level wake the core. Only reset brings `core_clk_en` back to 1.
- R6: An `irq_level` of 0 means no interrupt is pending. It never wakes the core, even when the threshold is 0.
- R7: `wake_pulse` is 1 for exactly the one cycle in which `core_clk_en` first returns to 1 after a stop. At all other times it is 0.
- R8: Writing 1 to bit 3 drives `bus_clk_oe` to 0. Later writes of 0 to that bit leave both the bit and the output unchanged until reset.
- R9: Bits 2:0 of the register always read as 0, whatever was written to them.
- R10: When a register write and a `stop_req` arrive at the same edge, the stop-arm value held before that write decides whether the stop is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Register port address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| stop_req | input | 1 | Stop request pulse from the core |
| irq_level | input | 3 | Priority of the highest pending interrupt, 0 when none |
| core_clk_en | output | 1 | Registered enable for the core clock gate |
| bus_clk_oe | output | 1 | Output-driver enable for the external bus clock |
| wake_pulse | output | 1 | One-cycle start of interrupt processing after wake |

## Verification
Two functions can land on one edge. The first is a stop request arriving together with a register write that changes the stop-arm bit. The second is a stop request arriving while a qualifying interrupt is already pending. The bench drives both cases: it writes 0x00 during an armed request, and it writes 0x80 during an unarmed one. It also holds an interrupt level of 7 through the stop edge. A behavioural reference model applies the pre-write arm value and takes the wake only on the following edge. Every output is compared against this model on every cycle.

// File: rtl/csw_pkg.sv
package csw_pkg;
  typedef enum logic {ST_RUN = 1'b0, ST_STOP = 1'b1} csw_state_e;

  typedef struct packed {
    logic       stop_en;
    logic [2:0] thr;
    logic       bus_dis;
  } csw_ctrl_t;
endpackage

// File: rtl/csw_ctrl_reg.sv
module csw_ctrl_reg
  import csw_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter logic [7:0]  REG_OFS = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output csw_ctrl_t         ctrl
);
  localparam logic [ADDR_W-1:0] SEL = ADDR_W'(REG_OFS);

  csw_ctrl_t ctrl_q, ctrl_d;
  logic      hit;

  assign hit = (addr == SEL);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en && hit) begin
      ctrl_d.stop_en = wdata[7];
      ctrl_d.thr     = wdata[6:4];
      // sticky: a write can only set the bus-clock disable
      ctrl_d.bus_dis = ctrl_q.bus_dis | wdata[3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign rdata = hit ? {ctrl_q.stop_en, ctrl_q.thr, ctrl_q.bus_dis, 3'b000} : 8'h00;
  assign ctrl  = ctrl_q;

  p_bus_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.bus_dis |=> ctrl_q.bus_dis);

  p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[2:0] == 3'b000);

  p_miss_nochg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit) |=> $stable(ctrl_q));
endmodule

// File: rtl/csw_wake_qual.sv
module csw_wake_qual #(
  parameter int unsigned LVL_W = 3
) (
  input  logic [LVL_W-1:0] irq_level,
  input  logic [LVL_W-1:0] thr,
  output logic             wake_ok
);
  localparam logic [LVL_W-1:0] NEVER = {LVL_W{1'b1}};
  localparam logic [LVL_W-1:0] NONE  = '0;

  always_comb begin
    wake_ok = 1'b0;
    if (thr != NEVER && irq_level != NONE)
      wake_ok = (irq_level > thr);
  end
endmodule

// File: rtl/csw_stop_fsm.sv
module csw_stop_fsm
  import csw_pkg::*;
#(
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic             stop_en,
  input  logic             wake_ok,
  input  logic [LVL_W-1:0] thr,
  input  logic [LVL_W-1:0] irq_level,
  output logic             core_clk_en,
  output logic             wake_pulse
);
  localparam logic [LVL_W-1:0] NEVER = {LVL_W{1'b1}};

  csw_state_e st_q, st_d;
  logic       en_q, wk_q;
  logic       en_d, wk_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:  if (stop_req && stop_en) st_d = ST_STOP;
      ST_STOP: if (wake_ok)             st_d = ST_RUN;
      default: st_d = ST_RUN;
    endcase
    en_d = (st_d == ST_RUN);
    wk_d = (st_q == ST_STOP) && (st_d == ST_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_RUN;
      en_q <= 1'b1;
      wk_q <= 1'b0;
    end else begin
      st_q <= st_d;
      en_q <= en_d;
      wk_q <= wk_d;
    end
  end

  assign core_clk_en = en_q;
  assign wake_pulse  = wk_q;

  p_unarmed_stay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && !stop_en) |=> core_clk_en);

  p_armed_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && stop_en && stop_req) |=> !core_clk_en);

  p_never_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_clk_en && thr == NEVER) |=> !core_clk_en);

  p_lvl0_nowake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_clk_en && irq_level == '0) |=> !core_clk_en);

  p_wake_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (core_clk_en && !$past(core_clk_en)));

  p_wake_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);
endmodule

// File: rtl/core_stop_wake.sv
module core_stop_wake
  import csw_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter logic [7:0]  REG_OFS = 8'h08,
  parameter int unsigned LVL_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              stop_req,
  input  logic [LVL_W-1:0]  irq_level,
  output logic              core_clk_en,
  output logic              bus_clk_oe,
  output logic              wake_pulse
);
  csw_ctrl_t        ctrl;
  logic             wake_ok;
  logic [LVL_W-1:0] thr;

  assign thr = LVL_W'(ctrl.thr);

  csw_ctrl_reg #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .ctrl  (ctrl)
  );

  csw_wake_qual #(.LVL_W(LVL_W)) u_qual (
    .irq_level (irq_level),
    .thr       (thr),
    .wake_ok   (wake_ok)
  );

  csw_stop_fsm #(.LVL_W(LVL_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_req    (stop_req),
    .stop_en     (ctrl.stop_en),
    .wake_ok     (wake_ok),
    .thr         (thr),
    .irq_level   (irq_level),
    .core_clk_en (core_clk_en),
    .wake_pulse  (wake_pulse)
  );

  assign bus_clk_oe = ~ctrl.bus_dis;
endmodule

// File: tb/sim_core_stop_wake.sv
module sim_core_stop_wake;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       stop_req = 1'b0;
  logic [2:0] irq_level = 3'd0;
  logic       core_clk_en, bus_clk_oe, wake_pulse;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  // reference model state
  bit       m_en;
  bit [2:0] m_thr;
  bit       m_bd;
  bit       m_run;
  bit       m_wake;

  always #5 clk = ~clk;

  core_stop_wake u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stop_req(stop_req),
    .irq_level(irq_level), .core_clk_en(core_clk_en),
    .bus_clk_oe(bus_clk_oe), .wake_pulse(wake_pulse)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp<=20000", cycles);
      finish_run();
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: act=0x%0h exp=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    int exp_rd;
    exp_rd = (reg_addr == 8'h08) ? {m_en, m_thr, m_bd, 3'b000} : 0;
    chk(tag, "rdata", int'(reg_rdata), exp_rd);
    chk(tag, "core_clk_en", int'(core_clk_en), int'(m_run));
    chk(tag, "bus_clk_oe", int'(bus_clk_oe), int'(!m_bd));
    chk(tag, "wake_pulse", int'(wake_pulse), int'(m_wake));
  endtask

  task automatic model_reset();
    m_en = 0; m_thr = 0; m_bd = 0; m_run = 1; m_wake = 0;
  endtask

  // one clock: drive inputs, let the edge happen, update model, compare at negedge
  task automatic step(input bit w, input bit [7:0] a, input bit [7:0] d,
                      input bit s, input bit [2:0] l, input string tag);
    bit       o_en;
    bit [2:0] o_thr;
    reg_wr = w; reg_addr = a; reg_wdata = d; stop_req = s; irq_level = l;
    @(posedge clk);
    o_en = m_en; o_thr = m_thr;
    if (w && a == 8'h08) begin
      m_en = d[7]; m_thr = d[6:4]; m_bd = m_bd | d[3];
    end
    m_wake = 0;
    if (m_run) begin
      if (s && o_en) m_run = 0;
    end else if (o_thr != 3'd7 && l != 0 && l > o_thr) begin
      m_run = 1; m_wake = 1;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0;
    reg_wr = 0; stop_req = 0; irq_level = 0; reg_addr = 8'h08;
    model_reset();
    #1;
    compare(tag);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    model_reset();
    do_reset("R1");
    step(0, 8'h08, 8'h00, 0, 0, "R1");
    // writes elsewhere are ignored; other addresses read zero
    step(1, 8'h0C, 8'hF8, 0, 0, "R2");
    step(0, 8'h0C, 8'h00, 0, 0, "R2");
    step(0, 8'h08, 8'h00, 0, 0, "R2");
    // unarmed stop ignored
    step(0, 8'h08, 8'h00, 1, 0, "R3");
    step(0, 8'h08, 8'h00, 0, 0, "R3");
    // reserved bits, bus disable sticky, threshold 7
    step(1, 8'h08, 8'hFF, 0, 0, "R9");
    step(0, 8'h08, 8'h00, 0, 0, "R9");
    step(1, 8'h08, 8'hF0, 0, 0, "R8");
    step(0, 8'h08, 8'h00, 1, 0, "R3");
    step(0, 8'h08, 8'h00, 1, 7, "R3");
    for (int k = 0; k < 6; k++) step(0, 8'h08, 8'h00, 0, 7, "R5");
    do_reset("R5");
    step(0, 8'h08, 8'h00, 0, 0, "R8");
    // threshold sweep against every level
    for (int n = 0; n < 7; n++) begin
      for (int l = 0; l < 8; l++) begin
        step(1, 8'h08, 8'h80 | 8'(n << 4), 0, 0, "R2");
        step(0, 8'h08, 8'h00, 1, 0, "R3");
        step(0, 8'h08, 8'h00, 0, 3'(l), (l == 0) ? "R6" : "R4");
        step(0, 8'h08, 8'h00, 0, 3'(l), "R4");
        step(0, 8'h08, 8'h00, 0, 7, "R7");
        step(0, 8'h08, 8'h00, 0, 0, "R7");
      end
    end
    // stop and a pending qualifying interrupt on the same edge
    step(1, 8'h08, 8'h80, 0, 0, "R10");
    step(0, 8'h08, 8'h00, 1, 7, "R10");
    step(0, 8'h08, 8'h00, 0, 7, "R7");
    step(0, 8'h08, 8'h00, 0, 0, "R7");
    // armed, disarming write on the stop edge: old value wins
    step(0, 8'h08, 8'h00, 0, 0, "R10");
    step(1, 8'h08, 8'h00, 1, 0, "R10");
    step(0, 8'h08, 8'h00, 0, 0, "R10");
    step(0, 8'h08, 8'h00, 0, 1, "R4");
    step(0, 8'h08, 8'h00, 0, 0, "R7");
    // disarmed, arming write on the stop edge: not taken
    step(1, 8'h08, 8'h80, 1, 0, "R10");
    step(0, 8'h08, 8'h00, 0, 0, "R10");
    do_reset("R1");
    step(0, 8'h08, 8'h00, 0, 0, "R1");
    finish_run();
  end
endmodule